// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block gathers system-management interrupt causes into one 32-bit status word and pairs it with a 32-bit enable word. Any status bit that is set and enabled drives a single active-low, registered SMI output. The exception is a fixed group of three positions, which never drives it. The status word holds three kinds of bit. Sticky bits latch a hardware event and are released by writing one to their position. Live bits follow an input level and never latch. Reserved bits always read zero.

Software reaches both words through a small register port. A one-bit select chooses between status and enable, and the read data is combinational. A separate observation port lets the block watch I/O writes on the system bus. Writes to the two controller ports, to the power-management command port, and to the port holding the sleep-request and firmware-release flags each set a sticky bit. All of these port addresses and flag positions are parameters. The expiry pulse of an external software timer sets one more sticky bit. Other sticky sources arrive on a per-bit set vector, and live sources arrive on a level vector.

Top module: `smi_stat_agg`

## Requirements
- R1: When a status bit outside positions 8..10 is 1 and its enable bit is 1, `smi_n` goes low one clock after that condition first holds. It returns high one clock after the last such pair is removed, whether by clearing the status bit or by clearing the enable bit.
- R2: Status bits 8, 9 and 10 never pull `smi_n` low, even when they are set and enabled.
- R3: Sticky bits 13, 16, 18, 25, 27 and 29 are set by `hw_set` at the same position and hold until software writes 1 there with `reg_sel`=0. Writing 0 leaves them unchanged. A `hw_set` bit at any other position has no effect.
- R4: Live bits 3, 8, 9, 10, 12, 17, 19, 20, 21, 22, 26, 28, 30 and 31 read as `live_lvl` at the same position. They ignore writes and do not latch. `live_lvl` at any other position has no effect.
- R5: Reserved positions 0, 1, 7, 14, 15, 23 and 24 read 0 in both the status word and the enable word.
- R6: An observed I/O write to address 62h or 66h sets status bit 11. Other addresses, and cycles with `io_wr` low, do not set it.
- R7: An observed I/O write to the command port address (default B2h) sets status bit 5.
- R8: An observed I/O write to the sleep port (default 404h) with data bit 13 at 1 sets status bit 4. An observed I/O write to the release port (default 428h) with data bit 2 at 1 sets status bit 2. The same writes with that data bit at 0 set nothing.
- R9: A one-cycle `tmr_expire` pulse sets status bit 6, which then holds until written with 1.
- R10: When a sticky bit is set by hardware and cleared by software in the same cycle, it ends up set.
- R11: After reset the status word reads 0 (with all inputs low), the enable word reads 0, and `smi_n` is 1.
- R12: The enable word is written and read with `reg_sel`=1 and holds the written value at all non-reserved positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (ones clear sticky status bits) |
| reg_rdata | output | 32 | Read data of the selected register |
| io_wr | input | 1 | Observed I/O write strobe |
| io_addr | input | 16 | Observed I/O write address |
| io_wdata | input | 32 | Observed I/O write data |
| hw_set | input | 32 | Per-position set pulses for externally sourced sticky bits |
| live_lvl | input | 32 | Per-position levels for live status bits |
| tmr_expire | input | 1 | Software timer expiry pulse |
| smi_n | output | 1 | Registered active-low SMI request |

## Verification
A hardware set and a software write-one-to-clear of the same sticky bit can land in the same clock. The bench provokes this by raising `hw_set[13]` while a status write with bit 13 at 1 is issued. It does the same with `tmr_expire` and a clear of bit 6. In both cases it expects the bit to read 1 afterwards. The SMI path is judged cycle by cycle: the output must still be high one sample after a status bit latches and must go low at the next sample. The same one-sample lag is checked when the cause is removed by a clear and when it is removed by disabling.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
   localparam int unsigned SMI_W = 32;

   // status bit positions fed by dedicated decode or the timer
   localparam int unsigned B_MC    = 11;
   localparam int unsigned B_PMCMD = 5;
   localparam int unsigned B_SLEEP = 4;
   localparam int unsigned B_REL   = 2;
   localparam int unsigned B_TMR   = 6;

   localparam logic [SMI_W-1:0] STICKY_M = 32'h2A05_2874;
   localparam logic [SMI_W-1:0] LIVE_M   = 32'hD47A_1708;
   localparam logic [SMI_W-1:0] NOSMI_M  = 32'h0000_0700;
   localparam logic [SMI_W-1:0] RSVD_M   = ~(STICKY_M | LIVE_M);
   localparam logic [SMI_W-1:0] LOCAL_M  = (SMI_W'(1) << B_MC) | (SMI_W'(1) << B_PMCMD) |
                                           (SMI_W'(1) << B_SLEEP) | (SMI_W'(1) << B_REL) |
                                           (SMI_W'(1) << B_TMR);
   localparam logic [SMI_W-1:0] EXT_M    = STICKY_M & ~LOCAL_M;
endpackage

// File: rtl/smi_io_decode.sv
module smi_io_decode #(
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 32,
   parameter logic [AW-1:0] MC_ADDR_A  = 16'h0062,
   parameter logic [AW-1:0] MC_ADDR_B  = 16'h0066,
   parameter logic [AW-1:0] PMCMD_ADDR = 16'h00B2,
   parameter logic [AW-1:0] SLEEP_ADDR = 16'h0404,
   parameter int unsigned SLEEP_BIT  = 13,
   parameter logic [AW-1:0] REL_ADDR   = 16'h0428,
   parameter int unsigned REL_BIT    = 2
) (
   input  logic          io_wr,
   input  logic [AW-1:0] io_addr,
   input  logic [DW-1:0] io_wdata,
   output logic          hit_mc,
   output logic          hit_pmcmd,
   output logic          hit_sleep,
   output logic          hit_rel
);
   if (SLEEP_BIT >= DW) begin : g_bad_sleep
      $error("smi_io_decode: SLEEP_BIT outside data width");
   end
   if (REL_BIT >= DW) begin : g_bad_rel
      $error("smi_io_decode: REL_BIT outside data width");
   end
   if (AW < 8) begin : g_bad_aw
      $error("smi_io_decode: address too narrow");
   end

   always_comb begin
      hit_mc    = io_wr && ((io_addr == MC_ADDR_A) || (io_addr == MC_ADDR_B));
      hit_pmcmd = io_wr && (io_addr == PMCMD_ADDR);
      hit_sleep = io_wr && (io_addr == SLEEP_ADDR) && io_wdata[SLEEP_BIT];
      hit_rel   = io_wr && (io_addr == REL_ADDR) && io_wdata[REL_BIT];
   end
endmodule

// File: rtl/smi_sticky_bank.sv
module smi_sticky_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W == 0) begin : g_bad_w
      $error("smi_sticky_bank: zero width");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end
         assign q_o[i] = q;

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]); // R10
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R3
         AST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i])); // R3
      end else begin : g_none
         assign q_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/smi_gen.sv
module smi_gen #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RSVD = '0,
   parameter logic [W-1:0] NOSMI = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] stat_i,
   output logic [W-1:0] en_o,
   output logic         smi_n_o
);
   localparam logic [W-1:0] EN_KEEP = ~RSVD;
   localparam logic [W-1:0] SMI_KEEP = ~NOSMI;

   logic [W-1:0] en_q;
   logic         cause;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else if (en_wr) en_q <= wdata & EN_KEEP;
   end

   assign cause = |(stat_i & en_q & SMI_KEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_n_o <= 1'b1;
      else smi_n_o <= ~cause;
   end

   assign en_o = en_q;

   AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o & RSVD) == '0); // R5
   AST_EN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_o)); // R12
endmodule

// File: rtl/smi_stat_agg.sv
module smi_stat_agg
   import smi_agg_pkg::*;
#(
   parameter int unsigned IO_AW      = 16,
   parameter int unsigned IO_DW      = 32,
   parameter logic [IO_AW-1:0] MC_ADDR_A  = 16'h0062,
   parameter logic [IO_AW-1:0] MC_ADDR_B  = 16'h0066,
   parameter logic [IO_AW-1:0] PMCMD_ADDR = 16'h00B2,
   parameter logic [IO_AW-1:0] SLEEP_ADDR = 16'h0404,
   parameter int unsigned SLEEP_BIT  = 13,
   parameter logic [IO_AW-1:0] REL_ADDR   = 16'h0428,
   parameter int unsigned REL_BIT    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic [SMI_W-1:0] reg_wdata,
   output logic [SMI_W-1:0] reg_rdata,
   input  logic             io_wr,
   input  logic [IO_AW-1:0] io_addr,
   input  logic [IO_DW-1:0] io_wdata,
   input  logic [SMI_W-1:0] hw_set,
   input  logic [SMI_W-1:0] live_lvl,
   input  logic             tmr_expire,
   output logic             smi_n
);
   if ((STICKY_M & LIVE_M) != '0) begin : g_bad_masks
      $error("smi_stat_agg: sticky and live masks overlap");
   end

   logic hit_mc, hit_pmcmd, hit_sleep, hit_rel;
   logic [SMI_W-1:0] set_vec, clr_vec, sticky_q, stat_w, en_w;

   smi_io_decode #(
      .AW(IO_AW), .DW(IO_DW), .MC_ADDR_A(MC_ADDR_A), .MC_ADDR_B(MC_ADDR_B),
      .PMCMD_ADDR(PMCMD_ADDR), .SLEEP_ADDR(SLEEP_ADDR), .SLEEP_BIT(SLEEP_BIT),
      .REL_ADDR(REL_ADDR), .REL_BIT(REL_BIT)
   ) u_dec (
      .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .hit_mc(hit_mc), .hit_pmcmd(hit_pmcmd), .hit_sleep(hit_sleep), .hit_rel(hit_rel)
   );

   always_comb begin
      set_vec          = hw_set & EXT_M;
      set_vec[B_MC]    = hit_mc;
      set_vec[B_PMCMD] = hit_pmcmd;
      set_vec[B_SLEEP] = hit_sleep;
      set_vec[B_REL]   = hit_rel;
      set_vec[B_TMR]   = tmr_expire;
      clr_vec          = (reg_wr && !reg_sel) ? reg_wdata : '0;
   end

   smi_sticky_bank #(.W(SMI_W), .MASK(STICKY_M)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(sticky_q)
   );

   assign stat_w = sticky_q | (live_lvl & LIVE_M);

   smi_gen #(.W(SMI_W), .RSVD(RSVD_M), .NOSMI(NOSMI_M)) u_gen (
      .clk(clk), .rst_n(rst_n), .en_wr(reg_wr && reg_sel), .wdata(reg_wdata),
      .stat_i(stat_w), .en_o(en_w), .smi_n_o(smi_n)
   );

   assign reg_rdata = reg_sel ? en_w : stat_w;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & RSVD_M) == '0); // R5
   AST_SMI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !smi_n |-> $past(|(stat_w & en_w & ~NOSMI_M))); // R2
   AST_MC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (io_addr == MC_ADDR_A || io_addr == MC_ADDR_B)) |=> stat_w[B_MC]); // R6
   AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire |=> stat_w[B_TMR]); // R9
   AST_PMCMD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PMCMD_ADDR) |=> stat_w[B_PMCMD]); // R7
endmodule

// File: tb/sim_smi_stat_agg.sv
`timescale 1ns/1ps
module sim_smi_stat_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [31:0] io_wdata = '0;
   logic [31:0] hw_set = '0, live_lvl = '0;
   logic        tmr_expire = 1'b0;
   logic        smi_n;

   int checks = 0, fails = 0;
   bit done = 0;

   localparam logic [31:0] EXT  = 32'h2A05_2000;
   localparam logic [31:0] LIVE = 32'hD47A_1708;
   localparam logic [31:0] ENRW = 32'hFE7F_3F7C;

   always #5 clk = ~clk;

   smi_stat_agg u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_wr(io_wr),
      .io_addr(io_addr), .io_wdata(io_wdata), .hw_set(hw_set),
      .live_lvl(live_lvl), .tmr_expire(tmr_expire), .smi_n(smi_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
   endtask

   task automatic iow(input logic [15:0] a, input logic [31:0] d);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_addr = '0; io_wdata = '0;
   endtask

   task automatic chk_stat(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(1'b0, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(1'b0, v); chk("R11 status", v, 32'h0);
      rd(1'b1, v); chk("R11 enable", v, 32'h0);
      chk("R11 smi_n", {31'b0, smi_n}, 32'h1);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v); chk("R12/R5 enable all ones", v, ENRW);
      wr(1'b1, 32'h1234_5678);
      rd(1'b1, v); chk("R12 enable pattern", v, 32'h1234_5678 & ENRW);
      wr(1'b1, 32'h0);
      rd(1'b1, v); chk("R12 enable zero", v, 32'h0);
   endtask

   task automatic t_sticky;
      hw_set = 32'hFFFF_FFFF;
      @(negedge clk); hw_set = '0;
      chk_stat("R3 latch ext only", EXT);
      repeat (3) @(negedge clk);
      chk_stat("R3 hold", EXT);
      wr(1'b0, 32'h0);
      chk_stat("R3 write zero no effect", EXT);
      wr(1'b0, 32'h0000_2000);
      chk_stat("R3 w1c bit13", EXT & ~32'h2000);
      wr(1'b0, 32'hFFFF_FFFF);
      chk_stat("R3 w1c all", 32'h0);
   endtask

   task automatic t_live;
      live_lvl = 32'hFFFF_FFFF; #1;
      chk_stat("R4/R5 live mirror", LIVE);
      wr(1'b0, 32'hFFFF_FFFF);
      chk_stat("R4 write ignored", LIVE);
      live_lvl = '0; #1;
      chk_stat("R4 no latch", 32'h0);
      @(negedge clk);
   endtask

   task automatic t_io;
      iow(16'h0062, 32'h0); chk_stat("R6 port 62h", 32'h800);
      wr(1'b0, 32'hFFFF_FFFF);
      iow(16'h0066, 32'h0); chk_stat("R6 port 66h", 32'h800);
      wr(1'b0, 32'hFFFF_FFFF);
      iow(16'h0064, 32'hFFFF_FFFF); chk_stat("R6 other port", 32'h0);
      io_addr = 16'h0062; @(negedge clk); io_addr = '0;
      chk_stat("R6 no strobe", 32'h0);
      iow(16'h00B2, 32'h0); chk_stat("R7 command port", 32'h20);
      wr(1'b0, 32'hFFFF_FFFF);
      iow(16'h0404, 32'h0000_2000); chk_stat("R8 sleep flag", 32'h10);
      wr(1'b0, 32'hFFFF_FFFF);
      iow(16'h0404, 32'hFFFF_DFFF); chk_stat("R8 sleep flag clear", 32'h0);
      iow(16'h0428, 32'h4); chk_stat("R8 release flag", 32'h4);
      wr(1'b0, 32'hFFFF_FFFF);
      iow(16'h0428, 32'hFFFF_FFFB); chk_stat("R8 release flag clear", 32'h0);
   endtask

   task automatic t_timer;
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      chk_stat("R9 timer set", 32'h40);
      repeat (2) @(negedge clk);
      chk_stat("R9 timer hold", 32'h40);
      wr(1'b0, 32'h40);
      chk_stat("R9 timer clear", 32'h0);
   endtask

   task automatic t_collide;
      hw_set = 32'h2000; reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h2000;
      @(negedge clk);
      hw_set = '0; reg_wr = 1'b0; reg_wdata = '0;
      chk_stat("R10 set beats clear bit13", 32'h2000);
      tmr_expire = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h40;
      @(negedge clk);
      tmr_expire = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      chk_stat("R10 set beats clear bit6", 32'h2040);
      wr(1'b0, 32'hFFFF_FFFF);
      chk_stat("R10 later clear", 32'h0);
   endtask

   task automatic t_smi;
      wr(1'b1, 32'h2000);
      hw_set = 32'h2000; @(negedge clk); hw_set = '0;
      chk("R1 smi lag", {31'b0, smi_n}, 32'h1);
      @(negedge clk);
      chk("R1 smi asserted", {31'b0, smi_n}, 32'h0);
      wr(1'b0, 32'h2000);
      chk("R1 smi lag on clear", {31'b0, smi_n}, 32'h0);
      @(negedge clk);
      chk("R1 smi released on clear", {31'b0, smi_n}, 32'h1);
      hw_set = 32'h2000; @(negedge clk); hw_set = '0;
      @(negedge clk);
      chk("R1 smi reasserted", {31'b0, smi_n}, 32'h0);
      wr(1'b1, 32'h0);
      chk("R1 smi lag on disable", {31'b0, smi_n}, 32'h0);
      @(negedge clk);
      chk("R1 smi released on disable", {31'b0, smi_n}, 32'h1);
      wr(1'b0, 32'hFFFF_FFFF);
   endtask

   task automatic t_excl;
      wr(1'b1, 32'h0000_1700);
      live_lvl = 32'h0000_0700;
      repeat (3) @(negedge clk);
      chk("R2 excluded bits no smi", {31'b0, smi_n}, 32'h1);
      live_lvl = 32'h0000_1700;
      repeat (2) @(negedge clk);
      chk("R1 live bit smi", {31'b0, smi_n}, 32'h0);
      live_lvl = 32'h0000_0700;
      repeat (2) @(negedge clk);
      chk("R2 back to excluded only", {31'b0, smi_n}, 32'h1);
      live_lvl = '0;
      wr(1'b1, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_sticky();
      t_live();
      t_io();
      t_timer();
      t_collide();
      t_smi();
      t_excl();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule